// File: doc/BRIEF.md
# Code Word Serializer with Two-Bit CRC

This block turns one transmission frame into a serial bit stream of 69 bits, least significant bit first, moving one bit per timing tick. A frame has one of two layouts. In the normal layout it carries a 32-bit hopping word, then a 32-bit serial field, then a supply status bit. In the seed layout it carries a 60-bit stored seed value and then the button nibble, followed by the same status bit. After the status bit come the two bits of a running CRC and two zero bits. The CRC covers bits 0 to 64 of the frame.

Supply status comes from one of two comparator flags, chosen by a trip-point select. The flag is read twice in each frame. The reading taken at start is the value that enters the CRC. The reading taken at the tick that ends bit 63 is the value transmitted as bit 64. The two readings can differ, so a receiver whose CRC fails can repeat the check with the other status value. A serial option can put the button status in place of the top nibble of the serial field.

Top module: `codeword_serializer`

## Requirements
- R1: After reset, busy_o, done_o and data_o are all 0.
- R2: A start_i pulse while idle raises busy_o from the next cycle. A start_i pulse while busy_o is high is ignored, including one in the same cycle as the tick that ends the last bit. The frame in progress is not disturbed.
- R3: Frame bit k appears on data_o from the tick that ends bit k-1 (from the start, for k = 0) until the tick that ends bit k. No other cycle changes it. In the normal layout, bits 0..31 are hop_i[0..31] and bits 32..63 are serial_i[0..31].
- R4: In the normal layout with ser28_i = 1, bits 60..63 are button_i[0..3] and not serial_i[28..31].
- R5: With seed_mode_i = 1, bits 0..59 are seed_i[0..59] and bits 60..63 are button_i[0..3], whatever the value of ser28_i.
- R6: lv_sel_i = 0 selects lv_3v_i and lv_sel_i = 1 selects lv_6v_i. A selected flag of 1 means the supply is below the trip point, and it is sent as a status bit of 1.
- R7: The selected flag is sampled in the cycle that start_i is accepted, and that sample is the bit-64 input to the CRC.
- R8: The selected flag is sampled again in the cycle of the tick that ends bit 63. That second sample is transmitted as bit 64. Flag changes at any other time have no effect on bit 64.
- R9: Both CRC bits start at 0. For each of bits 0..64 with input d, the next values are c1 = c0 xor d and c0 = c0 xor d xor c1. Bit 65 carries c0 and bit 66 carries c1.
- R10: Bits 67 and 68 are 0. In the cycle after the tick that ends bit 68, done_o is 1 for exactly one cycle and busy_o is 0.
- R11: data_o is 0 whenever busy_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a frame; ignored while busy |
| tick_i | input | 1 | Ends the current bit period |
| seed_mode_i | input | 1 | 1 selects the seed layout |
| ser28_i | input | 1 | 1 overlays the button status on the top serial nibble |
| hop_i | input | 32 | Hopping word |
| serial_i | input | 32 | Serial number |
| button_i | input | 4 | Button status |
| seed_i | input | 60 | Stored seed value |
| lv_sel_i | input | 1 | Trip-point select |
| lv_3v_i | input | 1 | Low-supply flag for the low trip point |
| lv_6v_i | input | 1 | Low-supply flag for the high trip point |
| data_o | output | 1 | Serial data |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle pulse after the last bit |

## Verification
Two pairs of events can fall in the same cycle. The first pair is the frame-ending tick and a new start request. The bench raises start_i together with the final tick and then expects busy_o to stay low after the done pulse. The second pair is the status sampling and the CRC accumulation. The flag is set to one value at start, flipped straight after, set again just before the tick that ends bit 63, and flipped once more. Bit 64 must show the second sample, while bits 65 and 66 must match a CRC that the bench computes with the first sample, over all 32 combinations of layout, serial option, trip select and the two sample values.

// File: rtl/cws_pkg.sv
package cws_pkg;

    localparam int HOP_W_DEF   = 32;
    localparam int SER_W_DEF   = 32;
    localparam int BTN_W_DEF   = 4;
    localparam int N_TRIP_DEF  = 2;
    localparam int TRAIL_W_DEF = 2;

    // One step of the two-bit check: {c1, c0} in, {c1, c0} out
    function automatic logic [1:0] crc2_next(input logic [1:0] cur, input logic din);
        logic [1:0] nxt;
        nxt[1] = cur[0] ^ din;
        nxt[0] = cur[0] ^ din ^ cur[1];
        return nxt;
    endfunction

endpackage

// File: rtl/cws_lv_select.sv
module cws_lv_select #(
    parameter int N_TRIP = 2,
    parameter int SEL_W  = (N_TRIP > 1) ? $clog2(N_TRIP) : 1
) (
    input  logic [N_TRIP-1:0] flags_i,
    input  logic [SEL_W-1:0]  sel_i,
    output logic              low_o
);

    always_comb begin
        low_o = 1'b0;
        for (int k = 0; k < N_TRIP; k++) begin
            if (sel_i == SEL_W'(k)) low_o = flags_i[k];
        end
    end

endmodule

// File: rtl/cws_body_build.sv
module cws_body_build #(
    parameter int HOP_W  = 32,
    parameter int SER_W  = 32,
    parameter int BTN_W  = 4,
    parameter int SEED_W = HOP_W + SER_W - BTN_W,
    parameter int BODY_W = HOP_W + SER_W
) (
    input  logic              seed_mode_i,
    input  logic              ser28_i,
    input  logic [HOP_W-1:0]  hop_i,
    input  logic [SER_W-1:0]  serial_i,
    input  logic [BTN_W-1:0]  button_i,
    input  logic [SEED_W-1:0] seed_i,
    output logic [BODY_W-1:0] body_o
);

    localparam int OVL_LO = SER_W - BTN_W;

    logic [SER_W-1:0] ser_fld;

    for (genvar i = 0; i < SER_W; i++) begin : g_ser
        if (i >= OVL_LO) begin : g_ovl
            assign ser_fld[i] = ser28_i ? button_i[i-OVL_LO] : serial_i[i];
        end else begin : g_keep
            assign ser_fld[i] = serial_i[i];
        end
    end

    assign body_o = seed_mode_i ? {button_i, seed_i} : {ser_fld, hop_i};

endmodule

// File: rtl/cws_bit_pick.sv
module cws_bit_pick #(
    parameter int BODY_W = 64,
    parameter int IDX_W  = 7
) (
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [BODY_W-1:0] body_i,
    input  logic              lv_tx_i,
    input  logic              lv_crc_i,
    input  logic [1:0]        crc_i,
    output logic              tx_bit_o,
    output logic              crc_bit_o
);

    localparam int BIDX_W = (BODY_W > 1) ? $clog2(BODY_W) : 1;
    localparam logic [IDX_W-1:0] STAT_IDX = IDX_W'(BODY_W);
    localparam logic [IDX_W-1:0] C0_IDX   = IDX_W'(BODY_W + 1);
    localparam logic [IDX_W-1:0] C1_IDX   = IDX_W'(BODY_W + 2);

    always_comb begin
        tx_bit_o  = 1'b0;
        crc_bit_o = 1'b0;
        if (idx_i < STAT_IDX) begin
            tx_bit_o  = body_i[idx_i[BIDX_W-1:0]];
            crc_bit_o = body_i[idx_i[BIDX_W-1:0]];
        end else if (idx_i == STAT_IDX) begin
            tx_bit_o  = lv_tx_i;
            crc_bit_o = lv_crc_i;
        end else if (idx_i == C0_IDX) begin
            tx_bit_o  = crc_i[0];
        end else if (idx_i == C1_IDX) begin
            tx_bit_o  = crc_i[1];
        end
    end

endmodule

// File: rtl/cws_crc_step.sv
module cws_crc_step (
    input  logic [1:0] crc_i,
    input  logic       din_i,
    output logic [1:0] crc_o
);

    import cws_pkg::*;

    assign crc_o = crc2_next(crc_i, din_i);

endmodule

// File: rtl/codeword_serializer.sv
module codeword_serializer #(
    parameter int HOP_W   = cws_pkg::HOP_W_DEF,
    parameter int SER_W   = cws_pkg::SER_W_DEF,
    parameter int BTN_W   = cws_pkg::BTN_W_DEF,
    parameter int N_TRIP  = cws_pkg::N_TRIP_DEF,
    parameter int TRAIL_W = cws_pkg::TRAIL_W_DEF,
    parameter int SEED_W  = HOP_W + SER_W - BTN_W,
    parameter int SEL_W   = (N_TRIP > 1) ? $clog2(N_TRIP) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              tick_i,
    input  logic              seed_mode_i,
    input  logic              ser28_i,
    input  logic [HOP_W-1:0]  hop_i,
    input  logic [SER_W-1:0]  serial_i,
    input  logic [BTN_W-1:0]  button_i,
    input  logic [SEED_W-1:0] seed_i,
    input  logic [SEL_W-1:0]  lv_sel_i,
    input  logic              lv_3v_i,
    input  logic              lv_6v_i,
    output logic              data_o,
    output logic              busy_o,
    output logic              done_o
);

    localparam int BODY_W    = HOP_W + SER_W;
    localparam int FRAME_LEN = BODY_W + 1 + 2 + TRAIL_W;
    localparam int IDX_W     = $clog2(FRAME_LEN);
    localparam logic [IDX_W-1:0] STAT_IDX = IDX_W'(BODY_W);
    localparam logic [IDX_W-1:0] PRE_STAT = IDX_W'(BODY_W - 1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);

    typedef struct packed {
        logic              busy;
        logic              done;
        logic [IDX_W-1:0]  idx;
        logic [1:0]        crc;
        logic              lv_crc;
        logic              lv_tx;
        logic [BODY_W-1:0] body;
    } state_t;

    state_t st_d, st_q;

    logic [N_TRIP-1:0] trip_flags;
    logic              lv_now;
    logic [BODY_W-1:0] body_new;
    logic              tx_bit;
    logic              crc_bit;
    logic [1:0]        crc_upd;

    always_comb begin
        trip_flags    = '0;
        trip_flags[0] = lv_3v_i;
        if (N_TRIP > 1) trip_flags[N_TRIP-1] = lv_6v_i;
    end

    cws_lv_select #(
        .N_TRIP (N_TRIP),
        .SEL_W  (SEL_W)
    ) lv_sel_u (
        .flags_i (trip_flags),
        .sel_i   (lv_sel_i),
        .low_o   (lv_now)
    );

    cws_body_build #(
        .HOP_W  (HOP_W),
        .SER_W  (SER_W),
        .BTN_W  (BTN_W),
        .SEED_W (SEED_W),
        .BODY_W (BODY_W)
    ) body_u (
        .seed_mode_i (seed_mode_i),
        .ser28_i     (ser28_i),
        .hop_i       (hop_i),
        .serial_i    (serial_i),
        .button_i    (button_i),
        .seed_i      (seed_i),
        .body_o      (body_new)
    );

    cws_bit_pick #(
        .BODY_W (BODY_W),
        .IDX_W  (IDX_W)
    ) pick_u (
        .idx_i     (st_q.idx),
        .body_i    (st_q.body),
        .lv_tx_i   (st_q.lv_tx),
        .lv_crc_i  (st_q.lv_crc),
        .crc_i     (st_q.crc),
        .tx_bit_o  (tx_bit),
        .crc_bit_o (crc_bit)
    );

    cws_crc_step crc_u (
        .crc_i (st_q.crc),
        .din_i (crc_bit),
        .crc_o (crc_upd)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.busy) begin
            if (start_i) begin
                st_d.busy   = 1'b1;
                st_d.idx    = '0;
                st_d.crc    = 2'b00;
                st_d.lv_crc = lv_now;
                st_d.lv_tx  = lv_now;
                st_d.body   = body_new;
            end
        end else if (tick_i) begin
            if (st_q.idx <= STAT_IDX) st_d.crc = crc_upd;
            if (st_q.idx == PRE_STAT) st_d.lv_tx = lv_now;
            if (st_q.idx == LAST_IDX) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
                st_d.idx  = '0;
            end else begin
                st_d.idx = st_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign data_o = st_q.busy & tx_bit;
    assign busy_o = st_q.busy;
    assign done_o = st_q.done;

endmodule

// File: rtl/codeword_serializer_chk.sv
module codeword_serializer_chk (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic tick_i,
    input logic data_o,
    input logic busy_o,
    input logic done_o
);

    p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    p_fall_only_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);

    p_hold_no_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !tick_i) |=> $stable(data_o));

    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_done_after_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !data_o);

endmodule

bind codeword_serializer codeword_serializer_chk chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .tick_i  (tick_i),
    .data_o  (data_o),
    .busy_o  (busy_o),
    .done_o  (done_o)
);

// File: tb/codeword_serializer_tb.sv
module codeword_serializer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        tick_i = 1'b0;
    logic        seed_mode_i = 1'b0;
    logic        ser28_i = 1'b0;
    logic [31:0] hop_i = '0;
    logic [31:0] serial_i = '0;
    logic [3:0]  button_i = '0;
    logic [59:0] seed_i = '0;
    logic        lv_sel_i = 1'b0;
    logic        lv_3v_i = 1'b0;
    logic        lv_6v_i = 1'b0;
    logic        data_o, busy_o, done_o;

    int n_chk = 0;
    int n_fail = 0;
    logic exp_bits [69];

    always #2 clk = ~clk;

    codeword_serializer dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .tick_i(tick_i),
        .seed_mode_i(seed_mode_i), .ser28_i(ser28_i), .hop_i(hop_i),
        .serial_i(serial_i), .button_i(button_i), .seed_i(seed_i),
        .lv_sel_i(lv_sel_i), .lv_3v_i(lv_3v_i), .lv_6v_i(lv_6v_i),
        .data_o(data_o), .busy_o(busy_o), .done_o(done_o)
    );

    task automatic check(input string req, input logic act, input logic exp, input int pos);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at %0d: actual %b expected %b", req, pos, act, exp);
        end
    endtask

    // Drive the selected flag to v and the other one to ~v
    task automatic set_low(input logic v);
        if (lv_sel_i) begin lv_6v_i = v; lv_3v_i = ~v; end
        else          begin lv_3v_i = v; lv_6v_i = ~v; end
    endtask

    task automatic build_expected(input logic s1, input logic s2);
        logic c0, c1, d, t;
        for (int i = 0; i < 64; i++) begin
            if (seed_mode_i) exp_bits[i] = (i < 60) ? seed_i[i] : button_i[i-60];
            else if (i < 32) exp_bits[i] = hop_i[i];
            else if (ser28_i && i >= 60) exp_bits[i] = button_i[i-60];
            else exp_bits[i] = serial_i[i-32];
        end
        exp_bits[64] = s2;
        c0 = 1'b0; c1 = 1'b0;
        for (int i = 0; i < 65; i++) begin
            d = (i == 64) ? s1 : exp_bits[i];
            t  = c0 ^ d ^ c1;
            c1 = c0 ^ d;
            c0 = t;
        end
        exp_bits[65] = c0;
        exp_bits[66] = c1;
        exp_bits[67] = 1'b0;
        exp_bits[68] = 1'b0;
    endtask

    function automatic string tag_of(input int i);
        if (i < 32) return seed_mode_i ? "R5" : "R3";
        if (i < 60) return seed_mode_i ? "R5" : "R3";
        if (i < 64) return seed_mode_i ? "R5" : (ser28_i ? "R4" : "R3");
        if (i == 64) return "R6/R8";
        if (i < 67) return "R7/R9";
        return "R10";
    endfunction

    task automatic run_frame(input int k, input logic s1, input logic s2,
                             input logic mid_start, input logic end_start);
        @(negedge clk);
        hop_i    = 32'h9E37_79B9 * (k + 1);
        serial_i = 32'h85EB_CA6B ^ (32'h0101_0101 * k);
        button_i = 4'(k * 5 + 3);
        seed_i   = {28'(32'hC2B2_AE35 * (k + 7)), 32'h27D4_EB2F + 32'(k)};
        build_expected(s1, s2);
        set_low(s1);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check("R2", busy_o, 1'b1, -1);
        set_low(~s1);
        for (int i = 0; i < 69; i++) begin
            @(negedge clk);
            check(tag_of(i), data_o, exp_bits[i], i);
            if (mid_start && i == 30) begin
                start_i = 1'b1;
                @(negedge clk);
                start_i = 1'b0;
                check("R2", data_o, exp_bits[i], i);
            end
            if (i == 63) set_low(s2);
            tick_i = 1'b1;
            if (end_start && i == 68) start_i = 1'b1;
            @(negedge clk);
            tick_i = 1'b0;
            start_i = 1'b0;
            if (i == 63) set_low(~s2);
        end
        check("R10", done_o, 1'b1, 69);
        check("R10", busy_o, 1'b0, 69);
        @(negedge clk);
        check("R10", done_o, 1'b0, 70);
        check("R2", busy_o, 1'b0, 70);
        check("R11", data_o, 1'b0, 70);
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int k;
        k = 0;
        repeat (3) @(negedge clk);
        check("R1", busy_o, 1'b0, 0);
        check("R1", done_o, 1'b0, 0);
        check("R1", data_o, 1'b0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11", data_o, 1'b0, 0);
        for (int m = 0; m < 2; m++) begin
            for (int x = 0; x < 2; x++) begin
                for (int s = 0; s < 2; s++) begin
                    for (int a = 0; a < 2; a++) begin
                        for (int b = 0; b < 2; b++) begin
                            seed_mode_i = m[0];
                            ser28_i     = x[0];
                            lv_sel_i    = s[0];
                            run_frame(k, a[0], b[0], (k % 3) == 1, (k % 2) == 0);
                            k++;
                        end
                    end
                end
            end
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule